// File: doc/BRIEF.md
# Byte-Lane Pin Interrupt Controller

This block watches two 16-pin general-purpose input ports and turns selected pin activity into one interrupt request. Each port is split into a low half (pins 0 to 7) and a high half (pins 8 to 15). Four 8-bit interrupt lanes make up a 32-bit interrupt vector. Lanes 0 and 2 each take a low half, and lanes 1 and 3 each take a high half. A single route bit per lane picks which of the two ports feeds it.

Every routed line is synchronised and then handled on its own. It can be level or edge sensitive, its polarity can be inverted, and it has a latch bit and a mask bit. The request output goes high while any latched bit is also unmasked.

Software drives the block over a small word-addressed register bus. Writes are single-cycle and reads are combinational. The configuration registers use separate set and clear addresses. The latch register is cleared by writing ones.

Top module: `pin_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00000000 and `irq` is low. Register addresses are: 0 route, 1 mask-set, 2 mask-clear, 3 edge-set, 4 edge-clear, 5 invert-set, 6 invert-clear, 7 latch. Any other address reads zero.
- R2: The route bit of lane k sits at bit 8k of the route register; 0 selects port A and 1 selects port B. Latch bits 8k+7..8k of lane k take pins 7..0 of the chosen port when k is even, and pins 15..8 of the chosen port when k is odd.
- R3: Route register bits other than 0, 8, 16 and 24 ignore writes and read as zero.
- R4: Mask, edge and invert are 32-bit registers. Writing their set address ORs the write data into the register, and writing their clear address clears the bits where the data is 1. Zero bits leave the register unchanged, and both addresses read back the current value.
- R5: A bit whose edge bit is 0 is level sensitive. Its latch bit equals the routed pin XOR its invert bit, and a latch clear write does not lower it while that value is 1.
- R6: With the edge bit 1 and the invert bit 0, a low-to-high pin change sets the latch bit. The bit then stays set after the pin returns low.
- R7: With the edge bit 1 and the invert bit 1, a high-to-low pin change sets the latch bit, and a low-to-high change does not. Changing the invert bit while the pin is steady sets nothing.
- R8: In edge mode, writing 1 to a latch register bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a latch clear write to that bit, the bit ends up set.
- R10: `irq` is high exactly when some bit is both latched and unmasked. It follows the latch one clock later.
- R11: A pin change that is stable before clock edge N reaches the latch at edge N+2. This is the result of a two-flop synchroniser followed by the latch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pa_pins | input | 16 | Port A pin levels (asynchronous) |
| pb_pins | input | 16 | Port B pin levels (asynchronous) |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The two actions that can meet in one cycle are a detected edge setting a latch bit and a software write-one clear of that same bit. The bench times a falling pin change so that the synchronised edge reaches the latch input in the same cycle as a latch clear write. It then judges the result by reading the latch register, where the bit must remain set. It also cycle-counts the path from pin to latch to `irq` and checks both the one-cycle lag of the request and the hold-off from the synchroniser.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the pin interrupt controller.
// Assumes a 4-bit word address on the register bus.
package pin_irq_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        A_ROUTE    = 4'd0,
        A_MASK_SET = 4'd1,
        A_MASK_CLR = 4'd2,
        A_EDGE_SET = 4'd3,
        A_EDGE_CLR = 4'd4,
        A_INV_SET  = 4'd5,
        A_INV_CLR  = 4'd6,
        A_LATCH    = 4'd7
    } reg_addr_e;
endpackage

// File: rtl/pin_irq_regs.sv
// Register file of the pin interrupt controller: route bits, set/clear
// pairs for mask, edge and invert, and the write-one-to-clear strobe for
// the latch. Assumes single-cycle writes and a combinational read port.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [LANES*LANE_W-1:0] bus_wdata,
    input  logic [LANES*LANE_W-1:0] latch_q,
    output logic [LANES-1:0]      route_sel,
    output logic [LANES*LANE_W-1:0] mask_q,
    output logic [LANES*LANE_W-1:0] edge_q,
    output logic [LANES*LANE_W-1:0] inv_q,
    output logic [LANES*LANE_W-1:0] latch_clr,
    output logic [LANES*LANE_W-1:0] bus_rdata
);
    localparam int NB = LANES * LANE_W;

    logic [NB-1:0] route_word;
    logic [NB-1:0] route_wmask;

    // Spread the route bits to their bus positions, one per lane.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_route_pos
            for (genvar b = 0; b < LANE_W; b++) begin : g_bit
                if (b == 0) begin : g_sel
                    assign route_word[l*LANE_W]  = route_sel[l];
                    assign route_wmask[l*LANE_W] = 1'b1;
                end else begin : g_zero
                    assign route_word[l*LANE_W+b]  = 1'b0;
                    assign route_wmask[l*LANE_W+b] = 1'b0;
                end
            end
        end
    endgenerate

    // Register updates from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_sel <= '0;
            mask_q    <= '0;
            edge_q    <= '0;
            inv_q     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_ROUTE: begin
                    for (int l = 0; l < LANES; l++)
                        route_sel[l] <= bus_wdata[l*LANE_W];
                end
                A_MASK_SET: mask_q <= mask_q | bus_wdata;
                A_MASK_CLR: mask_q <= mask_q & ~bus_wdata;
                A_EDGE_SET: edge_q <= edge_q | bus_wdata;
                A_EDGE_CLR: edge_q <= edge_q & ~bus_wdata;
                A_INV_SET:  inv_q  <= inv_q | bus_wdata;
                A_INV_CLR:  inv_q  <= inv_q & ~bus_wdata;
                default: ;
            endcase
        end
    end

    // Latch clear strobe, live only during a write to the latch address.
    always_comb begin
        latch_clr = (bus_wr && bus_addr == A_LATCH) ? bus_wdata : '0;
    end

    // Combinational read mux.
    always_comb begin
        case (bus_addr)
            A_ROUTE:                bus_rdata = route_word;
            A_MASK_SET, A_MASK_CLR: bus_rdata = mask_q;
            A_EDGE_SET, A_EDGE_CLR: bus_rdata = edge_q;
            A_INV_SET,  A_INV_CLR:  bus_rdata = inv_q;
            A_LATCH:                bus_rdata = latch_q;
            default:                bus_rdata = '0;
        endcase
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));
    // R3
    route_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ROUTE) |-> ((bus_rdata & ~route_wmask) == '0));
endmodule

// File: rtl/pin_irq_route.sv
// Lane router and synchroniser. Lane l takes the low half of the selected
// port when l is even and the high half when l is odd; route_sel[l] = 1
// picks port B. The routed bits then pass through two flops.
// Assumes pin inputs are asynchronous to clk.
module pin_irq_route #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*LANE_W-1:0]     pa_pins,
    input  logic [2*LANE_W-1:0]     pb_pins,
    input  logic [LANES-1:0]        route_sel,
    output logic [LANES*LANE_W-1:0] sync_q
);
    localparam int NB = LANES * LANE_W;

    logic [NB-1:0] routed;
    logic [NB-1:0] meta_q;

    // One multiplexer per lane, picking half and port.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int HALF = l % 2;
            assign routed[l*LANE_W +: LANE_W] = route_sel[l]
                ? pb_pins[HALF*LANE_W +: LANE_W]
                : pa_pins[HALF*LANE_W +: LANE_W];
        end
    endgenerate

    // Two-stage synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= routed;
            sync_q <= meta_q;
        end
    end
endmodule

// File: rtl/pin_irq_detect.sv
// Per-bit polarity, edge detection and latch. Level bits follow the
// polarity-adjusted input; edge bits set on a rising adjusted value and
// hold until cleared, with a same-cycle set taking priority over clear.
// Assumes sync_in is already synchronous to clk.
module pin_irq_detect #(
    parameter int NB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] sync_in,
    input  logic [NB-1:0] edge_q,
    input  logic [NB-1:0] inv_q,
    input  logic [NB-1:0] clr,
    output logic [NB-1:0] latch_q
);
    logic [NB-1:0] prev_q;
    logic [NB-1:0] pol;
    logic [NB-1:0] prev_pol;
    logic [NB-1:0] hit;
    logic [NB-1:0] latch_d;

    // Polarity adjustment and edge detection against last cycle.
    always_comb begin
        pol      = sync_in ^ inv_q;
        prev_pol = prev_q ^ inv_q;
        hit      = pol & ~prev_pol;
    end

    // Next latch value for each bit.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            if (edge_q[i])
                latch_d[i] = hit[i] | (latch_q[i] & ~clr[i]);
            else
                latch_d[i] = pol[i];
        end
    end

    // History and latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= sync_in;
            latch_q <= latch_d;
        end
    end

    generate
        for (genvar i = 0; i < NB; i++) begin : g_chk
            // R9
            edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_q[i] && hit[i]) |=> latch_q[i]);
            // R8
            edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_q[i] && !hit[i] && clr[i]) |=> !latch_q[i]);
            // R5
            level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_q[i] && (sync_in[i] != inv_q[i])) |=> latch_q[i]);
        end
    endgenerate
endmodule

// File: rtl/pin_irq_unit.sv
// Top of the pin interrupt controller: two 16-pin ports routed onto four
// 8-bit lanes, per-bit detection and latching, and a registered combined
// request. Assumes a synchronous active-low reset.
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*LANE_W-1:0]      pa_pins,
    input  logic [2*LANE_W-1:0]      pb_pins,
    input  logic [REG_AW-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [LANES*LANE_W-1:0]  bus_wdata,
    output logic [LANES*LANE_W-1:0]  bus_rdata,
    output logic                     irq
);
    localparam int NB = LANES * LANE_W;

    logic [LANES-1:0] route_sel;
    logic [NB-1:0]    mask_q;
    logic [NB-1:0]    edge_q;
    logic [NB-1:0]    inv_q;
    logic [NB-1:0]    latch_clr;
    logic [NB-1:0]    latch_q;
    logic [NB-1:0]    sync_q;
    logic             req_any;

    pin_irq_regs #(.LANES(LANES), .LANE_W(LANE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .latch_q(latch_q), .route_sel(route_sel),
        .mask_q(mask_q), .edge_q(edge_q), .inv_q(inv_q),
        .latch_clr(latch_clr), .bus_rdata(bus_rdata)
    );

    pin_irq_route #(.LANES(LANES), .LANE_W(LANE_W)) u_route (
        .clk(clk), .rst_n(rst_n), .pa_pins(pa_pins), .pb_pins(pb_pins),
        .route_sel(route_sel), .sync_q(sync_q)
    );

    pin_irq_detect #(.NB(NB)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .edge_q(edge_q),
        .inv_q(inv_q), .clr(latch_clr), .latch_q(latch_q)
    );

    // Any latched and unmasked bit.
    always_comb begin
        req_any = |(latch_q & mask_q);
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= req_any;
    end

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(latch_q & mask_q)));
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> !$past(|(latch_q & mask_q)));
endmodule

// File: tb/sim_pin_irq_unit.sv
module sim_pin_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pa_pins = '0;
    logic [15:0] pb_pins = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pin_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pa_pins(pa_pins), .pb_pins(pb_pins),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] route;
        logic [31:0] inv;
        logic [31:0] mask;
        logic [15:0] pa;
        logic [15:0] pb;
        logic [31:0] exp_latch;
        logic        exp_irq;
    } vec_t;

    // Level-mode vectors: route, invert, mask, pins, expected latch and irq (R2, R5, R10)
    localparam vec_t VECS [4] = '{
        '{32'h00000000, 32'h00000000, 32'h00000000, 16'h12F0, 16'h0000, 32'h12F012F0, 1'b0},
        '{32'h00000100, 32'h00000000, 32'h00008000, 16'h00A5, 16'h8000, 32'h00A580A5, 1'b1},
        '{32'h01010101, 32'hFFFF0000, 32'h80000000, 16'hFFFF, 16'h3C81, 32'hC37E3C81, 1'b1},
        '{32'h01000001, 32'h00000000, 32'h00FF0000, 16'hC300, 16'h0F0F, 32'h0F00C30F, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of all addresses and irq
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        // R3: unwritable route bits
        wr(4'd0, 32'hFFFFFFFF);
        rd(4'd0, v);
        check("R3 route readback", v, 32'h01010101);

        // Table walk (R2, R5, R10)
        foreach (VECS[i]) begin
            wr(4'd0, VECS[i].route);
            wr(4'd2, 32'hFFFFFFFF);
            wr(4'd1, VECS[i].mask);
            wr(4'd4, 32'hFFFFFFFF);
            wr(4'd6, 32'hFFFFFFFF);
            wr(4'd5, VECS[i].inv);
            @(negedge clk);
            pa_pins = VECS[i].pa; pb_pins = VECS[i].pb;
            settle();
            rd(4'd7, v);
            check("R2 lane routing latch", v, VECS[i].exp_latch);
            check("R10 irq from table", {31'b0, irq}, {31'b0, VECS[i].exp_irq});
        end

        // Edge setup: all lanes from port A, bit 3 edge mode, unmasked
        wr(4'd0, 32'h0);
        wr(4'd2, 32'hFFFFFFFF);
        wr(4'd6, 32'hFFFFFFFF);
        @(negedge clk);
        pa_pins = '0; pb_pins = '0;
        settle();
        wr(4'd3, 32'h00000008);
        wr(4'd1, 32'h00000008);
        wr(4'd7, 32'hFFFFFFFF);
        rd(4'd7, v);
        check("R8 latch cleared before edge tests", v & 32'h8, 32'h0);

        // R11 / R6 / R10: exact latency from pin to latch to irq
        bus_addr = 4'd7;
        @(negedge clk);
        pa_pins[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R11 latch not yet set after two edges", bus_rdata & 32'h8, 32'h0);
        @(negedge clk);
        check("R11 R6 latch set on rising edge", bus_rdata & 32'h8, 32'h8);
        check("R10 irq lags latch", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle later", {31'b0, irq}, 32'h1);

        // R6: holds after pin returns low
        pa_pins[3] = 1'b0;
        settle();
        rd(4'd7, v);
        check("R6 latch holds after fall", v & 32'h8, 32'h8);

        // R8: writing zero does nothing, writing one clears
        wr(4'd7, 32'h0);
        rd(4'd7, v);
        check("R8 zero write no effect", v & 32'h8, 32'h8);
        wr(4'd7, 32'h8);
        rd(4'd7, v);
        check("R8 one write clears", v & 32'h8, 32'h0);
        @(negedge clk);
        check("R10 irq low after clear", {31'b0, irq}, 32'h0);

        // R7: inverted polarity
        wr(4'd5, 32'h8);
        settle();
        rd(4'd7, v);
        check("R7 invert change sets nothing", v & 32'h8, 32'h0);
        @(negedge clk);
        pa_pins[3] = 1'b1;
        settle();
        rd(4'd7, v);
        check("R7 rising ignored when inverted", v & 32'h8, 32'h0);
        @(negedge clk);
        pa_pins[3] = 1'b0;
        settle();
        rd(4'd7, v);
        check("R7 falling sets when inverted", v & 32'h8, 32'h8);

        // R9: edge and clear land in the same cycle
        @(negedge clk);
        pa_pins[3] = 1'b1;
        settle();
        @(negedge clk);
        pa_pins[3] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 4'd7; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R9 set wins over clear", bus_rdata & 32'h8, 32'h8);
        wr(4'd7, 32'h8);
        rd(4'd7, v);
        check("R8 clear alone after R9", v & 32'h8, 32'h0);

        // R5: level mode cannot be cleared while active
        wr(4'd4, 32'h8);
        wr(4'd6, 32'h8);
        @(negedge clk);
        pa_pins[3] = 1'b1;
        settle();
        wr(4'd7, 32'h8);
        rd(4'd7, v);
        check("R5 level not cleared while active", v & 32'h8, 32'h8);
        @(negedge clk);
        pa_pins[3] = 1'b0;
        settle();
        rd(4'd7, v);
        check("R5 level follows input low", v & 32'h8, 32'h0);

        // R4: set/clear pair behaviour and dual readback
        wr(4'd1, 32'h000000F0);
        rd(4'd1, v);
        check("R4 mask set ORs", v, 32'h000000F8);
        wr(4'd2, 32'h00000008);
        rd(4'd2, v);
        check("R4 mask clear, read via clear address", v, 32'h000000F0);
        wr(4'd2, 32'h0);
        rd(4'd1, v);
        check("R4 zero clear no effect", v, 32'h000000F0);

        // R1: reset in mid-run
        @(negedge clk);
        pa_pins[3] = 1'b1;
        wr(4'd1, 32'h8);
        settle();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'd1, v);
        check("R1 mask after reset", v, 32'h0);
        rd(4'd3, v);
        check("R1 edge after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule